// File: doc/BRIEF.md
# Trap Value Selection Unit

When a core takes a synchronous exception, this unit decides which value goes into the trap-value register. The decision follows the cause code. A breakpoint reports the address of the instruction that raised it. An environment call reports zero. An illegal instruction reports its own instruction word. Fetch faults report the fetch address, and load or store faults report the data address. For environment calls and breakpoints, the encoding of the trapping instruction never reaches the output, whatever the privilege level.

The unit also chooses which register file level is written. It raises the supervisor write strobe when the trap is delegated and comes from below machine mode; otherwise it raises the machine write strobe. The selected value and the cause are registered, so they appear one cycle after the exception is presented. The delegation decision itself is made outside the unit and arrives as a single bit. Instruction decode, register storage and interrupts are also handled elsewhere.

Top module: `trap_value_sel`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tval_o`, `cause_o`, `m_we_o` and `s_we_o` are all zero.
- R2: For cause 3 (breakpoint), `tval_o` equals `pc_i` of the trapping instruction, never the instruction word, in every privilege level.
- R3: For causes 8, 9 and 11 (environment call from privilege 0, 1 and 3), `tval_o` is zero, even when `instr_i` holds an environment call or breakpoint encoding.
- R4: For cause 2 (illegal instruction), `tval_o` is `instr_i` zero-extended to XLEN bits.
- R5: For causes 0, 1 and 12 (fetch misaligned, fetch access fault, fetch page fault), `tval_o` equals `fetch_addr_i`.
- R6: For causes 4, 5, 6, 7, 13 and 15 (load or store misaligned, access fault or page fault), `tval_o` equals `data_addr_i`.
- R7: For any other cause code, `tval_o` is zero.
- R8: Privilege is encoded 0 user, 1 supervisor, 3 machine. When `deleg_i` is 1 and `priv_i` is not 3, `s_we_o` pulses and `m_we_o` stays low. Otherwise `m_we_o` pulses. The two strobes are never high together.
- R9: `tval_o`, `cause_o` and the strobe come from the inputs sampled at the rising edge where `exc_valid_i` is 1, and they appear one cycle later. `cause_o` equals the sampled `cause_i`.
- R10: When `exc_valid_i` is 0 at an edge, both strobes are 0 in the following cycle, and `tval_o` and `cause_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid_i | input | 1 | An exception is being taken this cycle |
| cause_i | input | CAUSE_W | Exception cause code |
| pc_i | input | XLEN | Virtual address of the trapping instruction |
| data_addr_i | input | XLEN | Faulting load/store virtual address |
| fetch_addr_i | input | XLEN | Faulting fetch virtual address |
| instr_i | input | 32 | Raw instruction word |
| priv_i | input | 2 | Privilege level of the trapping code |
| deleg_i | input | 1 | Trap is delegated to supervisor level |
| tval_o | output | XLEN | Selected trap value |
| cause_o | output | CAUSE_W | Registered cause code |
| m_we_o | output | 1 | Machine-level trap register write strobe |
| s_we_o | output | 1 | Supervisor-level trap register write strobe |

## Verification
Random exceptions draw every cause from 0 to 15, with independent 64-bit values on the PC, data address and fetch address inputs. This shows that each cause class takes its value from the correct source and not from one of the other address inputs. Directed cases drive the breakpoint encoding 0x00100073 and the environment-call encoding on `instr_i` while raising causes 3, 8, 9 and 11 at each privilege level. These cases separate a correct selection from one that leaks the instruction word. Idle cycles placed between exceptions check that values hold and that no strobe fires. Sweeping delegation against privilege 3 and lower privileges separates the two strobes.

// File: rtl/trap_value_sel.sv
module trap_value_sel #(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    data_addr_i,
  input  logic [XLEN-1:0]    fetch_addr_i,
  input  logic [31:0]        instr_i,
  input  logic [1:0]         priv_i,
  input  logic               deleg_i,
  output logic [XLEN-1:0]    tval_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               m_we_o,
  output logic               s_we_o
);
  localparam logic [1:0] PRIV_M = 2'd3;

  logic [XLEN-1:0] tval_sel;
  logic            to_super;

  assign to_super = deleg_i && (priv_i != PRIV_M);

  always_comb begin
    tval_sel = '0;
    case (int'(cause_i))
      0, 1, 12:              tval_sel = fetch_addr_i;
      2:                     tval_sel = {{(XLEN-32){1'b0}}, instr_i};
      3:                     tval_sel = pc_i;
      4, 5, 6, 7, 13, 15:    tval_sel = data_addr_i;
      default:               tval_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tval_o  <= '0;
      cause_o <= '0;
      m_we_o  <= 1'b0;
      s_we_o  <= 1'b0;
    end else begin
      m_we_o <= exc_valid_i && !to_super;
      s_we_o <= exc_valid_i && to_super;
      if (exc_valid_i) begin
        tval_o  <= tval_sel;
        cause_o <= cause_i;
      end
    end
  end
endmodule

module trap_value_sel_chk #(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               exc_valid_i,
  input logic [CAUSE_W-1:0] cause_i,
  input logic [XLEN-1:0]    pc_i,
  input logic [XLEN-1:0]    data_addr_i,
  input logic [XLEN-1:0]    fetch_addr_i,
  input logic [31:0]        instr_i,
  input logic [1:0]         priv_i,
  input logic               deleg_i,
  input logic [XLEN-1:0]    tval_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic               m_we_o,
  input logic               s_we_o
);
  AST_BREAK_PC: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_i && int'(cause_i) == 3 |=> tval_o == $past(pc_i)); // R2
  AST_ECALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_i && (int'(cause_i) == 8 || int'(cause_i) == 9 || int'(cause_i) == 11)
    |=> tval_o == '0); // R3
  AST_ILLEGAL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_i && int'(cause_i) == 2 |=> tval_o[31:0] == $past(instr_i) && tval_o[XLEN-1:32] == '0); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_we_o && s_we_o)); // R8
  AST_DELEG_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_i && deleg_i && priv_i != 2'd3 |=> s_we_o && !m_we_o); // R8
  AST_CAUSE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_i |=> cause_o == $past(cause_i)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid_i |=> !m_we_o && !s_we_o && $stable(tval_o) && $stable(cause_o)); // R10
endmodule

bind trap_value_sel trap_value_sel_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) chk_i (.*);

// File: tb/trap_value_sel_tb_top.sv
module trap_value_sel_tb_top;
  localparam int XLEN = 64;
  localparam int CW   = 5;
  localparam logic [31:0] ENC_BRK   = 32'h0010_0073;
  localparam logic [31:0] ENC_ECALL = 32'h0000_0073;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_valid_i = 1'b0;
  logic [CW-1:0]   cause_i = '0;
  logic [XLEN-1:0] pc_i = '0, data_addr_i = '0, fetch_addr_i = '0;
  logic [31:0]     instr_i = '0;
  logic [1:0]      priv_i = '0;
  logic            deleg_i = 1'b0;
  logic [XLEN-1:0] tval_o;
  logic [CW-1:0]   cause_o;
  logic            m_we_o, s_we_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [XLEN-1:0] e_tval = '0;
  logic [CW-1:0]   e_cause = '0;
  logic            e_m = 0, e_s = 0;

  always #10 clk = ~clk;

  trap_value_sel #(.XLEN(XLEN), .CAUSE_W(CW)) dut_i (.*);

  function automatic logic [XLEN-1:0] ref_tval(int c, logic [XLEN-1:0] pc,
      logic [XLEN-1:0] da, logic [XLEN-1:0] fa, logic [31:0] ins);
    case (c)
      3:                  return pc;
      8, 9, 11:           return '0;
      2:                  return {32'd0, ins};
      0, 1, 12:           return fa;
      4, 5, 6, 7, 13, 15: return da;
      default:            return '0;
    endcase
  endfunction

  function automatic string req_of(int c);
    case (c)
      3:                  return "R2";
      8, 9, 11:           return "R3";
      2:                  return "R4";
      0, 1, 12:           return "R5";
      4, 5, 6, 7, 13, 15: return "R6";
      default:            return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit v, int c, logic [1:0] pr, bit dl, logic [31:0] ins);
    string r;
    exc_valid_i  = v;
    cause_i      = CW'(c);
    priv_i       = pr;
    deleg_i      = dl;
    instr_i      = ins;
    pc_i         = {$urandom, $urandom};
    data_addr_i  = {$urandom, $urandom};
    fetch_addr_i = {$urandom, $urandom};
    if (v) begin
      e_tval  = ref_tval(c, pc_i, data_addr_i, fetch_addr_i, ins);
      e_cause = CW'(c);
    end
    e_s = v && dl && (pr != 2'd3);
    e_m = v && !e_s;
    @(negedge clk);
    r = v ? req_of(c) : "R10";
    check(r, tval_o, e_tval);
    check(v ? "R9" : "R10", XLEN'(cause_o), XLEN'(e_cause));
    check(v ? "R8" : "R10", XLEN'({m_we_o, s_we_o}), XLEN'({e_m, e_s}));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", tval_o, '0);
    check("R1", XLEN'({cause_o, m_we_o, s_we_o}), '0);
    rst_n = 1'b1;
    exc_valid_i = 1'b1;
    cause_i = CW'(3);
    @(negedge clk);
    exc_valid_i = 1'b0;
    check("R1", XLEN'({m_we_o, s_we_o}), XLEN'(2'b10));
    e_tval = tval_o; e_cause = cause_o;
    @(negedge clk);
    // directed: ecall/ebreak with their encodings on the instruction bus, every privilege
    for (int p = 0; p < 4; p++) begin
      step(1, 3, 2'(p), 0, ENC_BRK);
      step(1, 3, 2'(p), 1, ENC_BRK);
      step(0, 0, 2'(p), 0, ENC_BRK);
      step(1, 8, 2'(p), 1, ENC_ECALL);
      step(1, 9, 2'(p), 0, ENC_BRK);
      step(1, 11, 2'(p), 1, ENC_ECALL);
    end
    step(1, 2, 2'd3, 0, ENC_BRK);
    step(1, 2, 2'd0, 1, 32'hFFFF_FFFF);
    step(1, 12, 2'd1, 1, 32'h0);
    step(1, 15, 2'd0, 0, 32'h0);
    step(1, 14, 2'd3, 1, ENC_BRK);
    step(0, 3, 2'd0, 1, ENC_BRK);
    // constrained random
    for (int i = 0; i < 2000; i++) begin
      step(($urandom_range(3) != 0), int'($urandom_range(15)), 2'($urandom_range(3)),
           1'($urandom_range(1)), ($urandom_range(3) == 0) ? ENC_BRK : $urandom);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule